// File: doc/BRIEF.md
# Multiplexed ADC Channel Scan Sequencer

This block drives one shared analog-to-digital converter that sits behind an analog input multiplexer. Each pacer pulse starts a burst. The burst visits every enabled channel once, in ascending channel order. For each channel the block steers the multiplexer and waits out that channel's programmable settling time. It then issues a one-cycle conversion start and waits for the converter's done pulse, which carries a 12-bit sample. The sample is widened to a 32-bit word, by sign extension or by zero extension as that channel's polarity setting selects, and the word is written to a downstream FIFO.

The channel configuration consists of an enable bit, a polarity bit, a range-attenuator request bit and a settling-delay field for each channel. A global differential select halves the usable channel count. The block refuses an attenuator request on a unipolar channel. Two sticky error flags record problems: a pacer pulse that arrived during a burst, and a result that was lost to a full FIFO. A dedicated clear input resets both flags.

Top module: `adc_scan_seq`

## Requirements
- R1: During and after reset, before any pacer pulse, every output is zero: mux_sel_o, atten_o, adc_start_o, fifo_wr_o, fifo_data_o, busy_o, overrun_o and overflow_o.
- R2: A pacer pulse accepted while idle scans each eligible enabled channel exactly once, from lowest to highest index, and skips disabled channels. Channel c is enabled when ch_en_i[c]=1. Channel c is eligible when c < NUM_CH (32) with diff_mode_i=0, or when c < NUM_CH/2 (16) with diff_mode_i=1.
- R3: mux_sel_o takes the next channel c in the cycle after the pacer pulse or after the previous done pulse. adc_start_o then pulses high for exactly one cycle, D+1 cycles after mux_sel_o changed, where D = ch_dly_i[c*8 +: 8]. A delay of 0 gives a start in the cycle directly after the switch.
- R4: After a start, the block moves on only when adc_done_i arrives. A done pulse while no conversion is pending produces no write and no channel change.
- R5: For a channel with ch_bip_i[c]=1 (bipolar), fifo_data_o holds the sample in bits 11..0, and bits 31..12 are copies of sample bit 11.
- R6: For a channel with ch_bip_i[c]=0 (unipolar), fifo_data_o holds the sample in bits 11..0, and bits 31..12 are zero.
- R7: While a channel is selected, atten_o equals ch_atten_i[c] AND ch_bip_i[c]. atten_o is low while idle.
- R8: A pacer pulse during a burst is dropped, and overrun_o rises in the next cycle. flag_clr_i clears overrun_o and overflow_o. A set and a clear in the same cycle leave the flag set.
- R9: With no eligible enabled channel, a pacer pulse is ignored: busy_o stays low and no flag changes.
- R10: A done pulse while fifo_full_i=1 writes nothing and sets overflow_o, and the scan still proceeds to the next channel.
- R11: fifo_wr_o pulses one cycle after the done pulse with the formatted word. busy_o is high from the cycle after the accepted pacer pulse until the cycle after the burst's last done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pacer_i | input | 1 | Burst trigger pulse |
| flag_clr_i | input | 1 | Clears both sticky error flags |
| diff_mode_i | input | 1 | 1 = differential, only the lower half of the channels is eligible |
| ch_en_i | input | 32 | Per-channel enable |
| ch_bip_i | input | 32 | Per-channel polarity, 1 = bipolar |
| ch_atten_i | input | 32 | Per-channel attenuator request |
| ch_dly_i | input | 256 | Per-channel settling delay, 8 bits per channel |
| mux_sel_o | output | 5 | Selected multiplexer input |
| atten_o | output | 1 | Attenuator select for the current channel |
| adc_start_o | output | 1 | One-cycle conversion start |
| adc_done_i | input | 1 | Conversion done pulse |
| adc_data_i | input | 12 | Sample, valid with adc_done_i |
| fifo_full_i | input | 1 | Downstream FIFO full |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | 32 | Extended sample word |
| busy_o | output | 1 | Burst in progress |
| overrun_o | output | 1 | Sticky: pacer pulse arrived during a burst |
| overflow_o | output | 1 | Sticky: sample dropped because the FIFO was full |

## Verification
The assertions assume that the channel configuration (enable, polarity, attenuator and delay inputs, and the differential select) stays fixed while busy_o is high. The bench therefore changes configuration only after busy_o has fallen. They also assume that the converter answers each start with exactly one done pulse. The bench's converter model keeps to this: it returns a done pulse a set number of cycles after each start, and it injects a stray done pulse only while the block is idle.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_SETTLE = 2'd1,
        SQ_WAIT   = 2'd2
    } seq_state_e;

endpackage

// File: rtl/adc_scan_pick.sv
module adc_scan_pick #(
    parameter int NUM_CH = 32,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int IDX_W = CH_W + 1
) (
    input  logic [NUM_CH-1:0] mask_i,
    input  logic [IDX_W-1:0]  from_i,
    output logic              found_o,
    output logic [CH_W-1:0]   idx_o
);

    logic [NUM_CH-1:0] cand;

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_cand
        assign cand[gi] = mask_i[gi] && (IDX_W'(gi) >= from_i);
    end

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found_o = 1'b1;
                idx_o   = CH_W'(i);
            end
        end
    end

endmodule

// File: rtl/adc_scan_fmt.sv
module adc_scan_fmt #(
    parameter int DATA_W = 12,
    parameter int WORD_W = 32,
    localparam int EXT_W = WORD_W - DATA_W
) (
    input  logic [DATA_W-1:0] raw_i,
    input  logic              bipolar_i,
    output logic [WORD_W-1:0] word_o
);

    logic fill_bit;

    always_comb begin
        fill_bit = bipolar_i & raw_i[DATA_W-1];
        word_o   = {{EXT_W{fill_bit}}, raw_i};
    end

endmodule

// File: rtl/adc_scan_flags.sv
module adc_scan_flags #(
    parameter int NUM_FLAGS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] set_i,
    input  logic                 clr_i,
    output logic [NUM_FLAGS-1:0] flag_o
);

    logic [NUM_FLAGS-1:0] flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) begin
            flag_d = '0;
        end
        flag_d = flag_d | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag_o = flag_q;

    for (genvar gf = 0; gf < NUM_FLAGS; gf++) begin : g_chk
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[gf] && !clr_i) |=> flag_q[gf]); // R8
        AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[gf] |=> flag_q[gf]); // R8
    end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int DATA_W = 12,
    parameter int WORD_W = 32,
    parameter int DLY_W  = 8,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pacer_i,
    input  logic                    flag_clr_i,
    input  logic                    diff_mode_i,
    input  logic [NUM_CH-1:0]       ch_en_i,
    input  logic [NUM_CH-1:0]       ch_bip_i,
    input  logic [NUM_CH-1:0]       ch_atten_i,
    input  logic [NUM_CH*DLY_W-1:0] ch_dly_i,
    output logic [CH_W-1:0]         mux_sel_o,
    output logic                    atten_o,
    output logic                    adc_start_o,
    input  logic                    adc_done_i,
    input  logic [DATA_W-1:0]       adc_data_i,
    input  logic                    fifo_full_i,
    output logic                    fifo_wr_o,
    output logic [WORD_W-1:0]       fifo_data_o,
    output logic                    busy_o,
    output logic                    overrun_o,
    output logic                    overflow_o
);

    localparam int IDX_W   = CH_W + 1;
    localparam int HALF_CH = NUM_CH / 2;

    typedef struct packed {
        seq_state_e        state;
        logic [CH_W-1:0]   ch;
        logic [DLY_W-1:0]  cnt;
        logic              atten;
        logic              start;
        logic              wr;
        logic [WORD_W-1:0] data;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [NUM_CH-1:0] elig_mask;
    logic [IDX_W-1:0]  from_idx;
    logic              pick_found;
    logic [CH_W-1:0]   pick_idx;
    logic [DLY_W-1:0]  pick_dly;
    logic              pick_atten;
    logic [WORD_W-1:0] fmt_word;
    logic              ovr_set;
    logic              ovf_set;
    logic [1:0]        flags;

    for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_elig
        if (gc < HALF_CH) begin : g_low
            assign elig_mask[gc] = ch_en_i[gc];
        end else begin : g_high
            assign elig_mask[gc] = ch_en_i[gc] && !diff_mode_i;
        end
    end

    assign from_idx = (r_q.state == SQ_IDLE) ? '0 : ({1'b0, r_q.ch} + IDX_W'(1));

    adc_scan_pick #(
        .NUM_CH (NUM_CH)
    ) u_pick (
        .mask_i  (elig_mask),
        .from_i  (from_idx),
        .found_o (pick_found),
        .idx_o   (pick_idx)
    );

    assign pick_dly   = ch_dly_i[pick_idx*DLY_W +: DLY_W];
    assign pick_atten = ch_atten_i[pick_idx] & ch_bip_i[pick_idx];

    adc_scan_fmt #(
        .DATA_W (DATA_W),
        .WORD_W (WORD_W)
    ) u_fmt (
        .raw_i     (adc_data_i),
        .bipolar_i (ch_bip_i[r_q.ch]),
        .word_o    (fmt_word)
    );

    assign ovr_set = pacer_i && (r_q.state != SQ_IDLE);
    assign ovf_set = (r_q.state == SQ_WAIT) && adc_done_i && fifo_full_i;

    adc_scan_flags #(
        .NUM_FLAGS (2)
    ) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  ({ovf_set, ovr_set}),
        .clr_i  (flag_clr_i),
        .flag_o (flags)
    );

    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        r_d.wr    = 1'b0;
        case (r_q.state)
            SQ_IDLE: begin
                if (pacer_i && pick_found) begin
                    r_d.state = SQ_SETTLE;
                    r_d.ch    = pick_idx;
                    r_d.cnt   = pick_dly;
                    r_d.atten = pick_atten;
                end
            end
            SQ_SETTLE: begin
                if (r_q.cnt == '0) begin
                    r_d.start = 1'b1;
                    r_d.state = SQ_WAIT;
                end else begin
                    r_d.cnt = r_q.cnt - DLY_W'(1);
                end
            end
            SQ_WAIT: begin
                if (adc_done_i) begin
                    if (!fifo_full_i) begin
                        r_d.wr   = 1'b1;
                        r_d.data = fmt_word;
                    end
                    if (pick_found) begin
                        r_d.state = SQ_SETTLE;
                        r_d.ch    = pick_idx;
                        r_d.cnt   = pick_dly;
                        r_d.atten = pick_atten;
                    end else begin
                        r_d.state = SQ_IDLE;
                        r_d.atten = 1'b0;
                    end
                end
            end
            default: begin
                r_d.state = SQ_IDLE;
                r_d.atten = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: SQ_IDLE, ch: '0, cnt: '0, atten: 1'b0,
                     start: 1'b0, wr: 1'b0, data: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mux_sel_o   = r_q.ch;
    assign atten_o     = r_q.atten;
    assign adc_start_o = r_q.start;
    assign fifo_wr_o   = r_q.wr;
    assign fifo_data_o = r_q.data;
    assign busy_o      = (r_q.state != SQ_IDLE);
    assign overrun_o   = flags[0];
    assign overflow_o  = flags[1];

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start_o |=> !adc_start_o); // R3
    AST_START_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start_o |-> ch_en_i[mux_sel_o]); // R2
    AST_UNIPOLAR_ATTEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !ch_bip_i[mux_sel_o]) |-> !atten_o); // R7
    AST_IDLE_ATTEN: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !atten_o); // R7
    AST_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_o |-> !$past(fifo_full_i)); // R10
    AST_WRITE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_o |-> $past(adc_done_i)); // R11
    AST_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_o |-> (fifo_data_o[DATA_W-1:0] == $past(adc_data_i))); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !adc_start_o); // R11

endmodule

// File: tb/adc_scan_seq_tb_top.sv
module adc_scan_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 32;
    localparam int DW  = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pacer = 1'b0;
    logic            flag_clr = 1'b0;
    logic            diff_mode = 1'b0;
    logic [NCH-1:0]  cfg_en = '0;
    logic [NCH-1:0]  cfg_bip = '0;
    logic [NCH-1:0]  cfg_att = '0;
    logic [NCH*DW-1:0] cfg_dly = '0;
    logic [4:0]      mux_sel;
    logic            atten;
    logic            adc_start;
    logic            adc_done = 1'b0;
    logic [11:0]     adc_data = '0;
    logic            fifo_full = 1'b0;
    logic            fifo_wr;
    logic [31:0]     fifo_data;
    logic            busy;
    logic            overrun;
    logic            overflow;

    int checks = 0;
    int fails  = 0;
    int lat = 1;
    int full_mode = 0;
    bit stray_done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_scan_seq dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pacer_i     (pacer),
        .flag_clr_i  (flag_clr),
        .diff_mode_i (diff_mode),
        .ch_en_i     (cfg_en),
        .ch_bip_i    (cfg_bip),
        .ch_atten_i  (cfg_att),
        .ch_dly_i    (cfg_dly),
        .mux_sel_o   (mux_sel),
        .atten_o     (atten),
        .adc_start_o (adc_start),
        .adc_done_i  (adc_done),
        .adc_data_i  (adc_data),
        .fifo_full_i (fifo_full),
        .fifo_wr_o   (fifo_wr),
        .fifo_data_o (fifo_data),
        .busy_o      (busy),
        .overrun_o   (overrun),
        .overflow_o  (overflow)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference
    int     q[$];
    int     m_phase = 0;
    int     m_ch = 0;
    int     m_cnt = 0;
    logic   m_att = 0, m_start = 0, m_wr = 0, m_ovr = 0, m_ovf = 0;
    logic [31:0] m_data = '0;
    string  m_data_req = "R5";
    logic   s_ovr, s_ovf;

    task automatic m_load(input int c);
        m_ch    = c;
        m_cnt   = int'(cfg_dly[c*DW +: DW]);
        m_att   = cfg_att[c] & cfg_bip[c];
        m_phase = 1;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            m_phase = 0; m_ch = 0; m_cnt = 0;
            m_att = 0; m_start = 0; m_wr = 0; m_ovr = 0; m_ovf = 0; m_data = '0;
        end else begin
            s_ovr = pacer && (m_phase != 0);
            s_ovf = 1'b0;
            m_start = 0;
            m_wr = 0;
            if (m_phase == 0) begin
                if (pacer) begin
                    q.delete();
                    for (int c = 0; c < (diff_mode ? NCH/2 : NCH); c++)
                        if (cfg_en[c]) q.push_back(c);
                    if (q.size() > 0) m_load(q.pop_front());
                end
            end else if (m_phase == 1) begin
                if (m_cnt == 0) begin
                    m_start = 1;
                    m_phase = 2;
                end else begin
                    m_cnt--;
                end
            end else if (adc_done) begin
                if (fifo_full) s_ovf = 1'b1;
                else begin
                    m_wr = 1;
                    m_data = cfg_bip[m_ch] ? {{20{adc_data[11]}}, adc_data} : {20'b0, adc_data};
                    m_data_req = cfg_bip[m_ch] ? "R5" : "R6";
                end
                if (q.size() > 0) m_load(q.pop_front());
                else begin
                    m_phase = 0;
                    m_att = 0;
                end
            end
            if (flag_clr) begin m_ovr = 0; m_ovf = 0; end
            if (s_ovr) m_ovr = 1;
            if (s_ovf) m_ovf = 1;
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 mux_sel", 32'(mux_sel), 32'(m_ch));
            chk("R7 atten", 32'(atten), 32'(m_att));
            chk("R3 start", 32'(adc_start), 32'(m_start));
            chk("R11 fifo_wr", 32'(fifo_wr), 32'(m_wr));
            chk({m_data_req, " fifo_data"}, fifo_data, m_data);
            chk("R11 busy", 32'(busy), 32'(m_phase != 0));
            chk("R8 overrun", 32'(overrun), 32'(m_ovr));
            chk("R10 overflow", 32'(overflow), 32'(m_ovf));
        end
    end

    // converter model and FIFO full driver
    int pend = 0;
    int samp = 0;
    initial begin
        forever begin
            @(negedge clk);
            adc_done = 1'b0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    adc_done = 1'b1;
                    case (samp % 5)
                        0: adc_data = 12'h7FF;
                        1: adc_data = 12'h800;
                        2: adc_data = 12'hFFF;
                        3: adc_data = 12'h000;
                        default: adc_data = 12'(samp * 37);
                    endcase
                    samp++;
                end
            end else if (adc_start) begin
                pend = lat;
            end else if (stray_done) begin
                adc_done = 1'b1;
                adc_data = 12'hA5A;
                stray_done = 1'b0;
            end
            case (full_mode)
                0: fifo_full = 1'b0;
                1: fifo_full = 1'b1;
                default: fifo_full = ($urandom % 3) == 0;
            endcase
        end
    end

    task automatic pulse_pacer();
        @(negedge clk); pacer = 1'b1;
        @(negedge clk); pacer = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy);
        @(negedge clk);
    endtask

    task automatic set_dly(input int c, input int d);
        cfg_dly[c*DW +: DW] = 8'(d);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset mux_sel", 32'(mux_sel), 0);
        chk("R1 reset outputs", {24'b0, atten, adc_start, fifo_wr, busy, overrun, overflow, 2'b0}, 0);
        chk("R1 reset data", fifo_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", 32'(busy), 0);

        // sparse channels, mixed delays and polarity
        cfg_en = 32'h8000_0025;
        cfg_bip = 32'h0000_0021;
        cfg_att = 32'hFFFF_FFFF;
        set_dly(2, 3); set_dly(31, 7);
        lat = 2;
        pulse_pacer();
        wait_idle();
        chk("R2 burst done", 32'(busy), 0);

        // differential: upper channels skipped
        diff_mode = 1'b1;
        cfg_en = 32'hF00F_0081;
        cfg_bip = 32'h0000_00FF;
        lat = 1;
        pulse_pacer();
        wait_idle();
        diff_mode = 1'b0;

        // no eligible channel
        cfg_en = 32'h0000_0000;
        pulse_pacer();
        @(negedge clk);
        chk("R9 stays idle", 32'(busy), 0);
        chk("R9 no overrun", 32'(overrun), 0);

        // stray done while idle
        stray_done = 1'b1;
        repeat (3) @(negedge clk);
        chk("R4 no write from stray done", 32'(fifo_wr), 0);
        chk("R4 stays idle", 32'(busy), 0);

        // overrun, clear collision
        cfg_en = 32'h0000_0F00;
        set_dly(8, 5);
        pulse_pacer();
        repeat (2) @(negedge clk);
        pacer = 1'b1; flag_clr = 1'b1;
        @(negedge clk);
        pacer = 1'b0; flag_clr = 1'b0;
        @(negedge clk);
        chk("R8 set wins over clear", 32'(overrun), 1);
        wait_idle();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        @(negedge clk);
        chk("R8 cleared", 32'(overrun), 0);

        // FIFO full drops words but scan continues
        full_mode = 1;
        pulse_pacer();
        wait_idle();
        chk("R10 overflow set", 32'(overflow), 1);
        full_mode = 0;
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;

        // random configurations
        for (int it = 0; it < 24; it++) begin
            cfg_en = $urandom;
            cfg_bip = $urandom;
            cfg_att = $urandom;
            diff_mode = 1'($urandom % 2);
            for (int c = 0; c < NCH; c++) set_dly(c, int'($urandom % 4));
            lat = 1 + int'($urandom % 3);
            full_mode = (it % 3 == 0) ? 2 : 0;
            pulse_pacer();
            if (it % 4 == 1) begin
                repeat (3) @(negedge clk);
                pacer = 1'b1;
                @(negedge clk);
                pacer = 1'b0;
            end
            wait_idle();
            if (it % 5 == 4) begin
                flag_clr = 1'b1;
                @(negedge clk);
                flag_clr = 1'b0;
            end
        end
        full_mode = 0;
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule